// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

This block carries data words in one direction between two unrelated clocks. A producer writes on the write clock and a consumer reads on the read clock. Each side has its own qualifier pins: a low-true select, a direction select, an enable and a side-channel select. Four conditions must all line up before a transfer happens, and the matching ready flag must be high as well. The write side reports whether there is room (input-ready) and whether the queue is nearly full. The read side reports whether the output register holds a fresh word (output-ready) and whether the queue is nearly empty. Both threshold offsets are static inputs.

Storage is a parameterized RAM of `2**AW` words. The consumer never sees the RAM directly. It sees a registered output stage that the block fills by itself whenever that stage is vacant. Once a word sits in the output stage it no longer counts as stored, so the queue holds up to `2**AW + 1` words in total. Write and read pointers cross between the clocks as Gray codes that carry one extra wrap bit. Each crossing uses a two-flop synchronizer, so every flag on a side depends only on registers clocked on that side.

Two small state machines control the block:
- **Write side.** After reset the write side steps `WS_HOLD0 → WS_HOLD1 → WS_RUN` on the first two write-clock edges. Input-ready can only be high in `WS_RUN`.
- **Read side.** The output stage is either `RS_VACANT` or `RS_LOADED`.
  - `RS_VACANT → RS_LOADED` happens on a load while the stage is empty.
  - `RS_LOADED → RS_LOADED` happens on a qualified read while the RAM still holds data, which refills the stage.
  - `RS_LOADED → RS_VACANT` happens on a qualified read while the RAM is empty.

Top module: `dual_clock_fifo`

## Requirements
- R1: A write is accepted on a rising `wr_clk` edge only if all of the following hold at that edge: `wr_cs_n`=0, `wr_we`=1, `wr_en`=1, `wr_mb`=0 and `wr_ir`=1. With any one of these violated, no word enters the queue.
- R2: A read is qualified only if all of the following hold: `rd_cs_n`=0, `rd_we`=0, `rd_en`=1, `rd_mb`=0 and `rd_or`=1. A read attempt that fails any condition leaves `rd_data` and `rd_or` unchanged. In particular, while `rd_or`=0, read attempts do nothing and `rd_data` keeps the last word.
- R3: A word written into an empty queue appears on `rd_data` on the third rising `rd_clk` edge after the write. `rd_or` rises on that same edge and is 0 after the first and second edges.
- R4: While `rd_or`=1, `rd_data` changes only on an edge with a qualified read. On that edge it advances to the next stored word.
- R5: From a full queue, one read drives `wr_ir` high on the second rising `wr_clk` edge after the read. `wr_ir` is still 0 after the first edge.
- R6: `rd_ae_n` is 0 when the RAM holds at most `ae_lvl` words and 1 when it holds `ae_lvl`+1 or more, once settled. It is never 1 while the true RAM count is `ae_lvl` or less.
- R7: `wr_af_n` is 0 when the RAM holds at least `2**AW - af_lvl` words and 1 otherwise, once settled. It is never 1 while the true RAM count is `2**AW - af_lvl` or more.
- R8: The word in the output register is not counted as stored. With no reads, exactly `2**AW + 1` writes are accepted before `wr_ir` stays 0. `wr_ir` is never 1 while the RAM is full.
- R9: While `rst_n`=0, `wr_ir`=0, `rd_or`=0, `rd_ae_n`=0 and `wr_af_n`=1. After release, `wr_ir` is 0 after the first `wr_clk` edge and 1 after the second.
- R10: Words leave in exactly the order they were accepted, under concurrent traffic on both clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| rst_n | input | 1 | Active-low reset for both sides; hold for four edges of each clock |
| wr_cs_n | input | 1 | Write-side select, low true |
| wr_we | input | 1 | Write-side direction, 1 = write |
| wr_en | input | 1 | Write-side enable, high true |
| wr_mb | input | 1 | Write-side side-channel select; must be 0 to reach the queue |
| wr_data | input | DW | Word to enqueue |
| af_lvl | input | AW | Almost-full offset Y |
| wr_ir | output | 1 | Input-ready: room in the RAM |
| wr_af_n | output | 1 | Almost-full flag, low true |
| rd_cs_n | input | 1 | Read-side select, low true |
| rd_we | input | 1 | Read-side direction, 0 = read |
| rd_en | input | 1 | Read-side enable, high true |
| rd_mb | input | 1 | Read-side side-channel select; must be 0 to read the queue |
| ae_lvl | input | AW | Almost-empty offset X |
| rd_data | output | DW | Registered output word |
| rd_or | output | 1 | Output-ready: `rd_data` holds an unread word |
| rd_ae_n | output | 1 | Almost-empty flag, low true |

## Verification
Two events can fall on the same read edge:
- A qualified read can consume the output word on the same edge that refills it from the RAM.
- On a write edge, a write can land on the same edge where a slot freed by a read becomes visible.

Random traffic provokes both. The two clocks run at 4 ns and 7 ns, so their edges never align. The writer uses random gaps and random enable, and keeps the queue pressed against full. The reader reads at random enable. Each read edge compares `rd_data` against the head of a queue model. Each edge on either side checks that no ready or level flag is optimistic against the exact stored count, which is written words minus consumed words minus the output-ready bit.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    // write-side wake-up sequence after reset release
    typedef enum logic [1:0] {
        WS_HOLD0 = 2'd0,
        WS_HOLD1 = 2'd1,
        WS_RUN   = 2'd2
    } wake_t;

    // read-side output register occupancy
    typedef enum logic {
        RS_VACANT = 1'b0,
        RS_LOADED = 1'b1
    } outst_t;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer.
module dcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_store.sv
`timescale 1ns/1ps
// Word storage: written on the write clock, read combinationally by address.
module dcf_store #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wside.sv
`timescale 1ns/1ps
// Write-side control: qualification, write pointer, input-ready, almost-full.
module dcf_wside import dcf_pkg::*; #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we,
    input  logic          en,
    input  logic          mb,
    input  logic [AW:0]   rgray_s,
    input  logic [AW-1:0] af_lvl,
    output logic          fire,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          ir,
    output logic          af_n
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] FULLV = PW'(DEPTH);

    wake_t         st, st_nx;
    logic [PW-1:0] wptr, wptr_nx, rbin, used, thr;

    // Gray to binary of the synchronized read pointer
    always_comb begin
        for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
    end

    // next-state
    always_comb begin
        st_nx = st;
        unique case (st)
            WS_HOLD0: st_nx = WS_HOLD1;
            WS_HOLD1: st_nx = WS_RUN;
            WS_RUN:   st_nx = WS_RUN;
            default:  st_nx = WS_HOLD0;
        endcase
    end

    // state and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= WS_HOLD0;
            wptr  <= '0;
            wgray <= '0;
        end else begin
            st    <= st_nx;
            wptr  <= wptr_nx;
            wgray <= wptr_nx ^ (wptr_nx >> 1);
        end
    end

    // outputs
    always_comb begin
        used    = wptr - rbin;
        thr     = FULLV - {1'b0, af_lvl};
        ir      = (st == WS_RUN) && (used != FULLV);
        af_n    = (used < thr);
        fire    = !cs_n && we && en && !mb && ir;
        wptr_nx = wptr + {{AW{1'b0}}, fire};
        waddr   = wptr[AW-1:0];
    end

    // R9: input-ready never rises on the first edge after reset release
    p_ir_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ir |-> ($past(st) != WS_HOLD0));

    // R8: an accepted write never overfills the RAM
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (used <= FULLV));

    // R7: a full RAM always shows almost-full
    p_full_af_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_RUN && !ir) |-> !af_n);
endmodule

// File: rtl/dcf_rside.sv
`timescale 1ns/1ps
// Read-side control: output register, read pointer, output-ready, almost-empty.
module dcf_rside import dcf_pkg::*; #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we,
    input  logic          en,
    input  logic          mb,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_lvl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          or_o,
    output logic          ae_n
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] FULLV = PW'(DEPTH);

    outst_t        st, st_nx;
    logic [PW-1:0] rptr, rptr_nx, wbin, stored;
    logic          mem_empty, rd_ok, load;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
    end

    // outputs and datapath controls
    always_comb begin
        stored    = wbin - rptr;
        mem_empty = (stored == '0);
        or_o      = (st == RS_LOADED);
        rd_ok     = !cs_n && !we && en && !mb && or_o;
        load      = !mem_empty && (!or_o || rd_ok);
        rptr_nx   = rptr + {{AW{1'b0}}, load};
        ae_n      = (stored > {1'b0, ae_lvl});
        raddr     = rptr[AW-1:0];
    end

    // next-state
    always_comb begin
        st_nx = st;
        unique case (st)
            RS_VACANT: if (load)               st_nx = RS_LOADED;
            RS_LOADED: if (rd_ok && mem_empty) st_nx = RS_VACANT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= RS_VACANT;
            rptr  <= '0;
            rgray <= '0;
            dout  <= '0;
        end else begin
            st    <= st_nx;
            rptr  <= rptr_nx;
            rgray <= rptr_nx ^ (rptr_nx >> 1);
            if (load) dout <= mem_rdata;
        end
    end

    // R2: a vacant output register keeps its word unless a load makes it ready
    p_vacant_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !or_o |=> (or_o || $stable(dout)));

    // R4: a loaded word stays put without a qualified read
    p_loaded_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (or_o && !rd_ok) |=> (or_o && $stable(dout)));

    // R3: output-ready only rises when the RAM held data
    p_or_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(or_o) |-> $past(!mem_empty));

    // R8: the read view never sees more than a full RAM
    p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stored <= FULLV);
endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_cs_n,
    input  logic          wr_we,
    input  logic          wr_en,
    input  logic          wr_mb,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] af_lvl,
    output logic          wr_ir,
    output logic          wr_af_n,
    input  logic          rd_cs_n,
    input  logic          rd_we,
    input  logic          rd_en,
    input  logic          rd_mb,
    input  logic [AW-1:0] ae_lvl,
    output logic [DW-1:0] rd_data,
    output logic          rd_or,
    output logic          rd_ae_n
);
    localparam int PW = AW + 1;

    logic          fire;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [DW-1:0] mem_rdata;

    dcf_store #(.DW(DW), .AW(AW)) u_store (
        .wclk(wr_clk), .we(fire), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_wside #(.AW(AW)) u_wside (
        .clk(wr_clk), .rst_n(rst_n),
        .cs_n(wr_cs_n), .we(wr_we), .en(wr_en), .mb(wr_mb),
        .rgray_s(rgray_s), .af_lvl(af_lvl),
        .fire(fire), .waddr(waddr), .wgray(wgray),
        .ir(wr_ir), .af_n(wr_af_n)
    );

    dcf_rside #(.DW(DW), .AW(AW)) u_rside (
        .clk(rd_clk), .rst_n(rst_n),
        .cs_n(rd_cs_n), .we(rd_we), .en(rd_en), .mb(rd_mb),
        .wgray_s(wgray_s), .ae_lvl(ae_lvl), .mem_rdata(mem_rdata),
        .raddr(raddr), .rgray(rgray), .dout(rd_data),
        .or_o(rd_or), .ae_n(rd_ae_n)
    );
endmodule

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_fifo;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;
    localparam int XL = 2;
    localparam int YL = 2;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic wr_cs_n = 1'b1, wr_we = 1'b0, wr_en = 1'b0, wr_mb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic rd_cs_n = 1'b1, rd_we = 1'b1, rd_en = 1'b0, rd_mb = 1'b0;
    logic [AW-1:0] af_lvl = AW'(YL);
    logic [AW-1:0] ae_lvl = AW'(XL);
    logic wr_ir, wr_af_n, rd_or, rd_ae_n;
    logic [DW-1:0] rd_data;

    dual_clock_fifo #(.DW(DW), .AW(AW)) i_dual_clock_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_cs_n(wr_cs_n), .wr_we(wr_we), .wr_en(wr_en), .wr_mb(wr_mb),
        .wr_data(wr_data), .af_lvl(af_lvl), .wr_ir(wr_ir), .wr_af_n(wr_af_n),
        .rd_cs_n(rd_cs_n), .rd_we(rd_we), .rd_en(rd_en), .rd_mb(rd_mb),
        .ae_lvl(ae_lvl), .rd_data(rd_data), .rd_or(rd_or), .rd_ae_n(rd_ae_n)
    );

    // 250 MHz write clock; read clock 7 ns, edges never coincide
    always #2 wr_clk = ~wr_clk;
    initial begin
        #1.5;
        forever begin
            rd_clk = ~rd_clk;
            #3.5;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0, mon_on = 1'b0;
    logic [DW-1:0] q[$];
    int wr_total = 0, rd_total = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_try(input logic [DW-1:0] d, input bit cs_n, input bit we,
                          input bit en, input bit mb, output bit took);
        @(negedge wr_clk);
        wr_cs_n = cs_n; wr_we = we; wr_en = en; wr_mb = mb; wr_data = d;
        took = !cs_n && we && en && !mb && wr_ir;
        @(posedge wr_clk);
        wr_en <= 1'b0;
        if (took) begin
            q.push_back(d);
            wr_total++;
        end
    endtask

    task automatic rd_try(input bit en, input bit cs_n, input bit we, input bit mb,
                          output bit took);
        @(negedge rd_clk);
        rd_cs_n = cs_n; rd_we = we; rd_en = en; rd_mb = mb;
        took = en && !cs_n && !we && !mb && rd_or;
        @(posedge rd_clk);
        rd_en <= 1'b0;
        if (took && q.size() > 0) begin
            void'(q.pop_front());
            rd_total++;
        end
    endtask

    // read-clock reference comparison (R10, R6 safety)
    always @(posedge rd_clk) begin
        int mc;
        #1;
        if (mon_on) begin
            mc = wr_total - rd_total - int'(rd_or);
            if (rd_or) begin
                check(q.size() > 0, "R10 ready with empty model", int'(rd_or), 0);
                if (q.size() > 0)
                    check(rd_data == q[0], "R10 order", int'(rd_data), int'(q[0]));
            end
            check(!rd_ae_n || mc >= XL + 1, "R6 almost-empty optimistic", mc, XL + 1);
        end
    end

    // write-clock safety comparison (R8, R7)
    always @(posedge wr_clk) begin
        int mc;
        #1;
        if (mon_on) begin
            mc = wr_total - rd_total - int'(rd_or);
            check(!wr_ir || mc < DEPTH, "R8 input-ready optimistic", mc, DEPTH);
            check(!wr_af_n || mc < DEPTH - YL, "R7 almost-full optimistic", mc, DEPTH - YL);
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit ok;
        int acc;
        acc = 0;
        #30;
        check(!wr_ir, "R9 ir in reset", int'(wr_ir), 0);
        check(!rd_or, "R9 or in reset", int'(rd_or), 0);
        check(!rd_ae_n, "R9 ae in reset", int'(rd_ae_n), 0);
        check(wr_af_n, "R9 af in reset", int'(wr_af_n), 1);
        #11 rst_n = 1'b1;
        @(posedge wr_clk); #1;
        check(!wr_ir, "R9 ir after first edge", int'(wr_ir), 0);
        @(posedge wr_clk); #1;
        check(wr_ir, "R9 ir after second edge", int'(wr_ir), 1);
        mon_on = 1'b1;

        // R1: each disqualified write leaves the queue empty
        wr_try(16'h1111, 1'b1, 1'b1, 1'b1, 1'b0, ok);
        wr_try(16'h2222, 1'b0, 1'b0, 1'b1, 1'b0, ok);
        wr_try(16'h3333, 1'b0, 1'b1, 1'b0, 1'b0, ok);
        wr_try(16'h4444, 1'b0, 1'b1, 1'b1, 1'b1, ok);
        repeat (8) @(posedge rd_clk);
        #1 check(!rd_or, "R1 ignored writes", int'(rd_or), 0);

        // R3: fall-through on the third read edge
        wr_try(16'hA5A5, 1'b0, 1'b1, 1'b1, 1'b0, ok);
        @(posedge rd_clk); #1;
        check(!rd_or, "R3 edge one", int'(rd_or), 0);
        @(posedge rd_clk); #1;
        check(!rd_or, "R3 edge two", int'(rd_or), 0);
        @(posedge rd_clk); #1;
        check(rd_or, "R3 edge three ready", int'(rd_or), 1);
        check(rd_data == 16'hA5A5, "R3 edge three data", int'(rd_data), 32'hA5A5);

        // R2: disqualified reads do nothing
        rd_try(1'b1, 1'b1, 1'b0, 1'b0, ok);
        rd_try(1'b1, 1'b0, 1'b1, 1'b0, ok);
        rd_try(1'b1, 1'b0, 1'b0, 1'b1, ok);
        rd_try(1'b0, 1'b0, 1'b0, 1'b0, ok);
        #1 check(rd_or && rd_data == 16'hA5A5, "R2 junk reads ignored", int'(rd_data), 32'hA5A5);
        rd_try(1'b1, 1'b0, 1'b0, 1'b0, ok);
        #1 check(!rd_or, "R2 drained", int'(rd_or), 0);
        rd_try(1'b1, 1'b0, 1'b0, 1'b0, ok);
        #1 check(!rd_or && rd_data == 16'hA5A5, "R2 read while not ready", int'(rd_data), 32'hA5A5);

        // R4: advance only on a qualified read
        wr_try(16'h0101, 1'b0, 1'b1, 1'b1, 1'b0, ok);
        wr_try(16'h0202, 1'b0, 1'b1, 1'b1, 1'b0, ok);
        wr_try(16'h0303, 1'b0, 1'b1, 1'b1, 1'b0, ok);
        repeat (6) @(posedge rd_clk);
        #1 check(rd_or && rd_data == 16'h0101, "R4 first word", int'(rd_data), 32'h0101);
        repeat (3) rd_try(1'b0, 1'b0, 1'b0, 1'b0, ok);
        #1 check(rd_data == 16'h0101, "R4 idle hold", int'(rd_data), 32'h0101);
        rd_try(1'b1, 1'b0, 1'b0, 1'b0, ok);
        #1 check(rd_or && rd_data == 16'h0202, "R4 advance", int'(rd_data), 32'h0202);
        rd_try(1'b1, 1'b0, 1'b0, 1'b0, ok);
        #1 check(rd_or && rd_data == 16'h0303, "R4 advance again", int'(rd_data), 32'h0303);
        rd_try(1'b1, 1'b0, 1'b0, 1'b0, ok);
        #1 check(!rd_or, "R4 drained", int'(rd_or), 0);

        // R8: capacity counts the output register separately
        repeat (60) begin
            wr_try(DW'(32'h1000 + acc), 1'b0, 1'b1, 1'b1, 1'b0, ok);
            if (ok) acc++;
        end
        check(acc == DEPTH + 1, "R8 capacity", acc, DEPTH + 1);
        #1 check(!wr_ir, "R8 full", int'(wr_ir), 0);
        repeat (4) @(posedge rd_clk);
        #1;
        check(!wr_af_n, "R7 full settled", int'(wr_af_n), 0);
        check(rd_ae_n, "R6 full settled", int'(rd_ae_n), 1);

        // R5: freed slot visible on the second write edge
        rd_try(1'b1, 1'b0, 1'b0, 1'b0, ok);
        @(posedge wr_clk); #1;
        check(!wr_ir, "R5 first write edge", int'(wr_ir), 0);
        @(posedge wr_clk); #1;
        check(wr_ir, "R5 second write edge", int'(wr_ir), 1);

        // R6 / R7: settled levels while draining (RAM count k)
        for (int k = DEPTH - 1; k >= 0; k--) begin
            repeat (3) @(posedge rd_clk);
            #1;
            check(wr_af_n == (k < DEPTH - YL), "R7 level", int'(wr_af_n), int'(k < DEPTH - YL));
            check(rd_ae_n == (k > XL), "R6 level", int'(rd_ae_n), int'(k > XL));
            rd_try(1'b1, 1'b0, 1'b0, 1'b0, ok);
        end
        #1 check(!rd_or, "R6 emptied", int'(rd_or), 0);

        // R10: concurrent random traffic
        fork
            begin
                for (int i = 0; i < 300; i++) begin
                    bit t;
                    t = 1'b0;
                    if ($urandom % 4 == 0)
                        wr_try(DW'($urandom), 1'b0, 1'b1, 1'b1, 1'b1, t);
                    while (!t)
                        wr_try(DW'($urandom), 1'b0, 1'b1, ($urandom % 3 != 0), 1'b0, t);
                end
            end
            begin
                bit rk;
                for (int j = 0; j < 2500; j++) begin
                    if ($urandom % 8 == 0)
                        rd_try(1'b1, 1'b0, 1'b0, 1'b1, rk);
                    else
                        rd_try(($urandom % 2 == 0), 1'b0, 1'b0, 1'b0, rk);
                end
            end
        join
        repeat (4) @(posedge rd_clk);
        #1;
        check(q.size() == 0, "R10 all words delivered", q.size(), 0);
        check(!rd_or, "R10 ends empty", int'(rd_or), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule